// File: doc/BRIEF.md
# Grouped Level-Interrupt Combiner

This block folds a wide bank of level-sensitive interrupt lines into one request line per group. Each group owns eight adjacent source lines. A group's request is high while at least one of its sources is both pending and enabled. Software controls the enables through a small synchronous 32-bit register port. It writes ones into a set location or a clear location. It can read the raw pending bits, the pending bits after masking, and a bitmap that holds one bit for each group request.

The pending state follows the source level and keeps no record of edges. A configuration input can freeze the pending state of the upper groups. When the combiner is wired so that only a limited number of its outputs are used, source activity on the unused groups then has no effect. Writes to locations that cannot be written leave all state unchanged and raise a one-cycle error pulse.

Top module: `icmb_top`

## Requirements
- R1: Source line n belongs to group n>>3 at bit n&7. Its pending bit takes the line's level on every clock edge, so a change is seen one cycle later, and no edge is latched.
- R2: The request of group g is high exactly when the AND of g's pending bits and g's enable mask is nonzero. It responds to the edge after a source change or an enable write.
- R3: Offsets below 0x100 form quads of 16 bytes. The quad index is offset[7:4] and selects groups 4q to 4q+3. Word offset[3:2] selects the function, and byte lane k (bits 8k+7:8k) belongs to group 4q+k.
- R4: Quad word 0 is enable-set, where each written 1 sets a mask bit. Quad word 1 is enable-clear, where each written 1 clears a mask bit. A written 0 leaves its bit unchanged.
- R5: A read of quad word 2 returns the raw pending bits. A read of quad word 3 returns the pending bits ANDed with the mask.
- R6: Offset 0x100 reads the requests of groups 0 to 31 at bit g. Offset 0x104 reads groups 32 to 63 at bit g-32. Both follow the live requests.
- R7: After reset all masks, all pending bits and all requests are zero. Quad words 0 and 1 always read zero.
- R8: While ext_mode_i is 1, the pending bits of every group g >= ext_max_i keep their value whatever the sources do. Groups below that limit behave as in R1.
- R9: A write to quad words 2 or 3, to 0x100 or 0x104, or to any offset at or above 0x108 changes no mask. bus_err_o is then 1 for the one cycle after the write edge.
- R10: bus_err_o is 0 after a legal write and in any cycle that follows a cycle with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 512 | Level interrupt sources, line n in group n>>3 |
| ext_mode_i | input | 1 | Enables freezing of upper groups |
| ext_max_i | input | 7 | First group frozen when ext_mode_i is 1 |
| bus_addr_i | input | 12 | Byte offset for reads and writes |
| bus_we_i | input | 1 | Write strobe, taken on the clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational from state |
| bus_err_o | output | 1 | One-cycle pulse after an illegal write |
| grp_irq_o | output | 64 | One request per group |

## Verification
On every cycle the assertions check several properties. The pending bits follow the sources one edge later, or hold in external mode. The masks stay put without a write, and the error pulse tracks illegal writes. The summary word agrees with the request outputs, and the set and clear words read zero. The bench scenarios are needed for the rest: the mapping of byte lanes to groups, the masked values for particular patterns, the one-cycle latency at the group outputs, the partial clears, and the proof that a rejected write left the masks as they were.

// File: rtl/icmb_pkg.sv
package icmb_pkg;
  localparam int unsigned SRC_PER_GRP  = 8;
  localparam int unsigned GRP_PER_QUAD = 4;
  localparam int unsigned QUAD_BYTES   = 16;

  typedef enum logic [1:0] {
    QW_EN_SET = 2'd0,
    QW_EN_CLR = 2'd1,
    QW_RAW    = 2'd2,
    QW_MASKED = 2'd3
  } qword_e;
endpackage

// File: rtl/icmb_rst_sync.sv
module icmb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/icmb_group_slice.sv
module icmb_group_slice #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         accept_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] mask_o,
  output logic         active_o
);
  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] mask_q, mask_d;
  logic         mask_en;

  always_comb begin
    pend_d  = accept_i ? src_i : pend_q;
    mask_en = |(set_i | clr_i);
    mask_d  = (mask_q | set_i) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign pend_o   = pend_q;
  assign mask_o   = mask_q;
  assign active_o = |(pend_q & mask_q);
endmodule

// File: rtl/icmb_regif.sv
module icmb_regif
  import icmb_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 64,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic                              we_i,
  input  logic [31:0]                       wdata_i,
  input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] pend_i,
  input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] mask_i,
  input  logic [NUM_GROUPS-1:0]             active_i,
  output logic [NUM_GROUPS*SRC_PER_GRP-1:0] set_o,
  output logic [NUM_GROUPS*SRC_PER_GRP-1:0] clr_o,
  output logic [31:0]                       rdata_o,
  output logic                              err_o
);
  localparam int unsigned NUM_QUADS = NUM_GROUPS / GRP_PER_QUAD;
  localparam int unsigned QIDX_W    = $clog2(NUM_QUADS);
  localparam int unsigned SUM_WORDS = NUM_GROUPS / 32;
  localparam logic [ADDR_W-1:0] SUM_BASE = ADDR_W'(NUM_QUADS * QUAD_BYTES);
  localparam logic [ADDR_W-1:0] SUM_END  = ADDR_W'(NUM_QUADS * QUAD_BYTES + SUM_WORDS * 4);

  logic              in_quads, in_sum, bad_wr, err_q, err_d;
  logic [QIDX_W-1:0] qidx;
  qword_e            qword;
  logic [ADDR_W-1:0] soff;
  logic              unused_addr_lsb;

  assign in_quads        = addr_i < SUM_BASE;
  assign in_sum          = !in_quads && (addr_i < SUM_END);
  assign qidx            = addr_i[QIDX_W+3:4];
  assign qword           = qword_e'(addr_i[3:2]);
  assign soff            = addr_i - SUM_BASE;
  assign unused_addr_lsb = ^addr_i[1:0];

  // enable-set / enable-clear strobes, one byte lane per group
  always_comb begin
    set_o = '0;
    clr_o = '0;
    if (we_i && in_quads) begin
      for (int k = 0; k < int'(GRP_PER_QUAD); k++) begin
        if (qword == QW_EN_SET)
          set_o[(int'(qidx) * GRP_PER_QUAD + k) * SRC_PER_GRP +: SRC_PER_GRP] = wdata_i[k*8 +: 8];
        if (qword == QW_EN_CLR)
          clr_o[(int'(qidx) * GRP_PER_QUAD + k) * SRC_PER_GRP +: SRC_PER_GRP] = wdata_i[k*8 +: 8];
      end
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (in_quads) begin
      for (int k = 0; k < int'(GRP_PER_QUAD); k++) begin
        if (qword == QW_RAW)
          rdata_o[k*8 +: 8] = pend_i[(int'(qidx) * GRP_PER_QUAD + k) * SRC_PER_GRP +: SRC_PER_GRP];
        else if (qword == QW_MASKED)
          rdata_o[k*8 +: 8] = pend_i[(int'(qidx) * GRP_PER_QUAD + k) * SRC_PER_GRP +: SRC_PER_GRP]
                            & mask_i[(int'(qidx) * GRP_PER_QUAD + k) * SRC_PER_GRP +: SRC_PER_GRP];
      end
    end else if (in_sum) begin
      rdata_o = active_i[int'(soff[ADDR_W-1:2]) * 32 +: 32];
    end
  end

  assign bad_wr = we_i && !(in_quads && (qword == QW_EN_SET || qword == QW_EN_CLR));
  assign err_d  = bad_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_o = err_q;
endmodule

// File: rtl/icmb_top.sv
module icmb_top
  import icmb_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 64,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] src_i,
  input  logic                              ext_mode_i,
  input  logic [$clog2(NUM_GROUPS):0]       ext_max_i,
  input  logic [ADDR_W-1:0]                 bus_addr_i,
  input  logic                              bus_we_i,
  input  logic [31:0]                       bus_wdata_i,
  output logic [31:0]                       bus_rdata_o,
  output logic                              bus_err_o,
  output logic [NUM_GROUPS-1:0]             grp_irq_o
);
  localparam int unsigned NUM_SRC = NUM_GROUPS * SRC_PER_GRP;
  localparam int unsigned GIDX_W  = $clog2(NUM_GROUPS);

  logic                  rst_s;
  logic [NUM_SRC-1:0]    pend_w, mask_w, set_w, clr_w;
  logic [NUM_GROUPS-1:0] accept_w;

  icmb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam logic [GIDX_W:0] GV = (GIDX_W+1)'(g);
    assign accept_w[g] = !ext_mode_i || (GV < ext_max_i);

    icmb_group_slice #(.W(SRC_PER_GRP)) u_slice (
      .clk      (clk),
      .rst_n    (rst_s),
      .src_i    (src_i[g*SRC_PER_GRP +: SRC_PER_GRP]),
      .accept_i (accept_w[g]),
      .set_i    (set_w[g*SRC_PER_GRP +: SRC_PER_GRP]),
      .clr_i    (clr_w[g*SRC_PER_GRP +: SRC_PER_GRP]),
      .pend_o   (pend_w[g*SRC_PER_GRP +: SRC_PER_GRP]),
      .mask_o   (mask_w[g*SRC_PER_GRP +: SRC_PER_GRP]),
      .active_o (grp_irq_o[g])
    );
  end

  icmb_regif #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_regif (
    .clk      (clk),
    .rst_n    (rst_s),
    .addr_i   (bus_addr_i),
    .we_i     (bus_we_i),
    .wdata_i  (bus_wdata_i),
    .pend_i   (pend_w),
    .mask_i   (mask_w),
    .active_i (grp_irq_o),
    .set_o    (set_w),
    .clr_o    (clr_w),
    .rdata_o  (bus_rdata_o),
    .err_o    (bus_err_o)
  );
endmodule

// File: rtl/icmb_chk.sv
module icmb_chk #(
  parameter int unsigned NUM_GROUPS = 64,
  parameter int unsigned ADDR_W     = 12
) (
  input logic                      clk,
  input logic                      rst_s,
  input logic [NUM_GROUPS*8-1:0]   src,
  input logic [NUM_GROUPS*8-1:0]   pend,
  input logic [NUM_GROUPS*8-1:0]   mask,
  input logic                      ext_mode,
  input logic [$clog2(NUM_GROUPS):0] ext_max,
  input logic [ADDR_W-1:0]         addr,
  input logic                      we,
  input logic [31:0]               rdata,
  input logic                      err,
  input logic [NUM_GROUPS-1:0]     irq
);
  localparam logic [ADDR_W-1:0] SUM_BASE = ADDR_W'(NUM_GROUPS * 4);
  localparam logic [ADDR_W-1:0] SUM_END  = ADDR_W'(NUM_GROUPS * 4 + NUM_GROUPS / 8);
  localparam logic [$clog2(NUM_GROUPS):0] TOP_G = ($clog2(NUM_GROUPS)+1)'(NUM_GROUPS - 1);

  logic armed;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1
  pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (armed && !ext_mode) |=> (pend == $past(src)));

  // R8
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (armed && ext_mode && ext_max <= TOP_G) |=> $stable(pend[NUM_GROUPS*8-1 -: 8]));

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (armed && !we) |=> $stable(mask));

  // R9
  bad_write_err_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (armed && we && addr >= SUM_END) |=> err);

  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (armed && !we) |=> !err);

  // R6
  summary_match_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (armed && addr == SUM_BASE) |-> (rdata == irq[31:0]));

  // R7
  setclr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (armed && addr < SUM_BASE && !addr[3]) |-> (rdata == 32'd0));

  // R2
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (armed && (|irq)) |-> (|(mask & pend)));
endmodule

bind icmb_top icmb_chk #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .src      (src_i),
  .pend     (pend_w),
  .mask     (mask_w),
  .ext_mode (ext_mode_i),
  .ext_max  (ext_max_i),
  .addr     (bus_addr_i),
  .we       (bus_we_i),
  .rdata    (bus_rdata_o),
  .err      (bus_err_o),
  .irq      (grp_irq_o)
);

// File: tb/sim_icmb_top.sv
module sim_icmb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [511:0] src;
  logic         ext_mode;
  logic [6:0]   ext_max;
  logic [11:0]  addr;
  logic         we;
  logic [31:0]  wdata;
  logic [31:0]  rdata;
  logic         err;
  logic [63:0]  irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic last_err;
  logic [31:0] rv;

  always #5 clk = ~clk;

  icmb_top u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .ext_mode_i(ext_mode), .ext_max_i(ext_max),
    .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_err_o(err), .grp_irq_o(irq)
  );

  // {group[5:0], src byte, enable byte, expected masked byte}
  localparam logic [29:0] VECS [7] = '{
    {6'd0,  8'h01, 8'h01, 8'h01},
    {6'd3,  8'hF0, 8'h0F, 8'h00},
    {6'd17, 8'hAA, 8'hFF, 8'hAA},
    {6'd31, 8'h80, 8'hC0, 8'h80},
    {6'd32, 8'h3C, 8'h24, 8'h24},
    {6'd46, 8'h00, 8'hFF, 8'h00},
    {6'd63, 8'hFF, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    last_err = err;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src = '0; ext_mode = 1'b0; ext_max = 7'd0;
    addr = '0; we = 1'b0; wdata = '0; last_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7 reset state
    chk("R7 irq after reset", {32'd0, irq[63:32] | irq[31:0]}, 64'd0);
    rd(12'h100, rv); chk("R7 summary0 after reset", rv, 32'd0);
    rd(12'h00C, rv); chk("R7 masked after reset", rv, 32'd0);

    // R1 raw follows level, R7 set/clr read zero, R2 no mask -> no irq
    src[31:0] = 32'hFFFF_FFFF;
    @(negedge clk);
    rd(12'h008, rv); chk("R1 raw quad0", rv, 32'hFFFF_FFFF);
    rd(12'h000, rv); chk("R7 enable-set reads zero", rv, 32'd0);
    rd(12'h004, rv); chk("R7 enable-clear reads zero", rv, 32'd0);
    chk("R2 unmasked no irq", {28'd0, irq[3:0]}, 32'd0);
    src = '0;
    @(negedge clk);
    rd(12'h008, rv); chk("R1 raw cleared by low level", rv, 32'd0);

    // vector table: R3 lane mapping, R5 raw/masked, R6 summary, R2 output
    for (int i = 0; i < 7; i++) begin
      logic [5:0]  g;
      logic [7:0]  s, e, m;
      logic [11:0] qa;
      {g, s, e, m} = VECS[i];
      qa = {2'b00, g[5:2], 4'h0};
      src[g*8 +: 8] = s;
      wr(qa, {24'd0, e} << (8 * g[1:0]));
      chk("R2 group irq", {31'd0, irq[g]}, {31'd0, |m});
      rd(qa | 12'hC, rv); chk("R3/R5 masked lane", {24'd0, rv[8*g[1:0] +: 8]}, {24'd0, m});
      rd(qa | 12'h8, rv); chk("R5 raw lane", {24'd0, rv[8*g[1:0] +: 8]}, {24'd0, s});
      rd(g[5] ? 12'h104 : 12'h100, rv);
      chk("R6 summary bit", rv, (|m) ? (32'd1 << g[4:0]) : 32'd0);
      wr(qa | 12'h4, 32'hFF << (8 * g[1:0]));
      src[g*8 +: 8] = 8'h00;
      @(negedge clk);
    end

    // R4 partial clear, zero writes ineffective (group 5: quad 1 lane 1)
    src[47:40] = 8'hFF;
    wr(12'h010, 32'h0000_FF00);
    wr(12'h014, 32'h0000_0F00);
    wr(12'h010, 32'h0000_0000);
    wr(12'h014, 32'h0000_0000);
    rd(12'h01C, rv); chk("R4 set then partial clear", rv, 32'h0000_F000);

    // R9 illegal writes change no mask, R10 pulse width / legal write
    wr(12'h018, 32'hFFFF_FFFF); chk("R9 err on raw write", {31'd0, last_err}, 32'd1);
    @(negedge clk); chk("R10 err one cycle", {31'd0, err}, 32'd0);
    wr(12'h01C, 32'hFFFF_FFFF); chk("R9 err on masked write", {31'd0, last_err}, 32'd1);
    wr(12'h100, 32'hFFFF_FFFF); chk("R9 err on summary write", {31'd0, last_err}, 32'd1);
    wr(12'h108, 32'hFFFF_FFFF); chk("R9 err at 0x108", {31'd0, last_err}, 32'd1);
    wr(12'h7F0, 32'hFFFF_FFFF); chk("R9 err far offset", {31'd0, last_err}, 32'd1);
    rd(12'h01C, rv); chk("R9 masks unchanged", rv, 32'h0000_F000);
    wr(12'h014, 32'h0000_0000); chk("R10 legal write no err", {31'd0, last_err}, 32'd0);

    // R1/R2 one-cycle latency on group 5 (mask 0xF0)
    src[47:40] = 8'h00;
    @(negedge clk);
    chk("R2 irq low with src low", {31'd0, irq[5]}, 32'd0);
    src[47:40] = 8'h10;
    #1 chk("R1 irq not before edge", {31'd0, irq[5]}, 32'd0);
    @(negedge clk);
    chk("R1 irq after one edge", {31'd0, irq[5]}, 32'd1);
    src[47:40] = 8'h00;
    @(negedge clk);
    chk("R1 irq follows level low", {31'd0, irq[5]}, 32'd0);

    // R8 external mode: group 40 (quad 10 lane 0) frozen, group 10 (quad 2 lane 2) live
    wr(12'h0A0, 32'h0000_0001);
    wr(12'h020, 32'h0001_0000);
    ext_mode = 1'b1; ext_max = 7'd32;
    src[320] = 1'b1; src[80] = 1'b1;
    @(negedge clk);
    chk("R8 frozen group ignores rise", {31'd0, irq[40]}, 32'd0);
    chk("R8 live group below limit", {31'd0, irq[10]}, 32'd1);
    rd(12'h100, rv); chk("R6 summary word0 group10", rv, 32'h0000_0400);
    ext_mode = 1'b0;
    @(negedge clk);
    rd(12'h104, rv); chk("R6 summary word1 group40", rv, 32'h0000_0100);
    ext_mode = 1'b1;
    src[320] = 1'b0;
    @(negedge clk);
    chk("R8 frozen group ignores fall", {31'd0, irq[40]}, 32'd1);
    ext_mode = 1'b0;
    @(negedge clk);
    chk("R8 released group follows", {31'd0, irq[40]}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule